// File: doc/BRIEF.md
# Tileable Eleven-Input Column Compressor Slice

This block is one bit column of a multi-operand reduction tree. It takes eleven bits that all carry the same binary weight. It reduces them to two bits of that same weight. Along the way it emits carry bits of double weight toward the next column and absorbs carry bits of equal weight from the column below. The slice is a stack of full-adder levels. Each carry made at one level enters the level just above it in the neighbouring slice. Because of this, identical slices can be placed side by side across a product width and every column sees the same level-by-level delay. The pair of output bits per column then goes to an ordinary carry-propagate adder.

The adders are allocated level by level by a fixed rule. Each level packs as many complete full adders as its bit count allows and passes any leftover bits through. With eleven inputs this gives five levels of 3, 2, 2, 1 and 1 adders, which is nine carries each way. The parameter `NUM_IN` widens the slice to eighteen inputs. That gives six levels of 6, 4, 2, 2, 1 and 1 adders, which is sixteen carries each way. The lateral carry vectors are always `NUM_IN-2` bits wide. Slices are chained by connecting one slice's `carryOut` to the `carryIn` of the slice one weight higher. The lowest slice takes zeros or extra addend bits of its own weight.

Top module: `tile_counter_slice`

## Requirements
- R1: For any input, the number of ones on `inBits` plus the ones on `carryIn` equals the ones on `outBits` plus twice the ones on `carryOut`.
- R2: With `inBits` and `carryIn` all zero, `outBits` and `carryOut` are all zero, including directly after the bench's reset.
- R3: With `inBits` and `carryIn` all ones, every bit of `outBits` and of `carryOut` is one.
- R4: The first-level carries occupy `carryOut[F0-1:0]`, where F0 = floor(NUM_IN/3) (3 for eleven inputs). Bit i is the majority of `inBits[3i+2:3i]`, and it does not depend on `carryIn`.
- R5: `carryOut` and `carryIn` are grouped by level, lowest level at bit 0. For eleven inputs the groups have widths 3, 2, 2, 1, 1 and start at bits 0, 3, 5, 7, 8. Changing `carryIn` group g leaves `carryOut` groups 0 to g unchanged.
- R6: In a chain of four eleven-input slices, where slice k has weight 2^k and `carryOut` of slice k drives `carryIn` of slice k+1, two sums are equal for every input. The first is the weighted count of all input ones plus the count of ones on the lowest `carryIn`. The second is the weighted count of all `outBits` ones plus 16 times the count of ones on the top `carryOut`.
- R7: With `NUM_IN` = 18, the lateral vectors are 16 bits wide. The slice meets the R1 balance and the R2 and R3 cases. Its first-level carries are `carryOut[5:0]`, formed as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inBits | input | NUM_IN | Equal-weight bits to be compressed |
| carryIn | input | NUM_IN-2 | Carries from the next-lower slice, grouped by level |
| carryOut | output | NUM_IN-2 | Carries to the next-higher slice, grouped by level |
| outBits | output | 2 | Two result bits of the slice's own weight |

## Verification
The slice holds no state, so every result is due in the same cycle as the stimulus, after the adder levels settle. This covers `outBits`, every `carryOut` group, and the sums through a chain of four slices. The bench changes inputs just after a rising edge and reads the results at the falling edge half a period later. No extra cycle is allowed for and no edge race can occur. The test for a changed carry-in group first reads a baseline vector and then the modified one, each in its own cycle. The unchanged lower groups are compared between those two reads.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  // Bits present at the entry of level lvl for a slice of nIn inputs.
  // Each level turns every group of three into one sum, and the neighbour
  // adds back one carry per adder, so the width shrinks by the adder count.
  function automatic int stageWidth(input int nIn, input int lvl);
    int b;
    b = nIn;
    for (int k = 0; k < lvl; k++) b = b - b / 3;
    return b;
  endfunction

  function automatic int stageAdders(input int nIn, input int lvl);
    return stageWidth(nIn, lvl) / 3;
  endfunction

  function automatic int stageCount(input int nIn);
    int b;
    int c;
    b = nIn;
    c = 0;
    while (b > 2) begin
      b = b - b / 3;
      c++;
    end
    return c;
  endfunction

  // Position of a level's first carry inside the lateral vectors.
  function automatic int carryBase(input int nIn, input int lvl);
    int s;
    s = 0;
    for (int k = 0; k < lvl; k++) s += stageAdders(nIn, k);
    return s;
  endfunction

endpackage

// File: rtl/tcs_full_adder.sv
module tcs_full_adder (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);
  logic halfSum;
  assign halfSum = a ^ b;
  assign s       = halfSum ^ c;
  assign co      = (a & b) | (c & halfSum);
endmodule

// File: rtl/tcs_level.sv
module tcs_level #(
  parameter int IN_W = 11,
  parameter int FA_N = 3
) (
  input  logic [IN_W-1:0]      lvlIn,
  input  logic [FA_N-1:0]      lateralIn,
  output logic [IN_W-FA_N-1:0] lvlOut,
  output logic [FA_N-1:0]      lateralOut
);
  localparam int PASS_N   = IN_W - 3 * FA_N;
  localparam int CIN_BASE = IN_W - 2 * FA_N;

  // Output order: sums, then untouched bits, then carries from the neighbour.
  for (genvar i = 0; i < FA_N; i++) begin : gAdder
    tcs_full_adder uFa (
      .a (lvlIn[3*i]),
      .b (lvlIn[3*i+1]),
      .c (lvlIn[3*i+2]),
      .s (lvlOut[i]),
      .co(lateralOut[i])
    );
    assign lvlOut[CIN_BASE+i] = lateralIn[i];
  end

  for (genvar j = 0; j < PASS_N; j++) begin : gPass
    assign lvlOut[FA_N+j] = lvlIn[3*FA_N+j];
  end
endmodule

// File: rtl/tile_counter_slice.sv
module tile_counter_slice
  import tcs_pkg::*;
#(
  parameter int NUM_IN = 11,
  localparam int LEVELS = stageCount(NUM_IN),
  localparam int CARRY_W = NUM_IN - 2
) (
  input  logic [NUM_IN-1:0]  inBits,
  input  logic [CARRY_W-1:0] carryIn,
  output logic [CARRY_W-1:0] carryOut,
  output logic [1:0]         outBits
);

  for (genvar l = 0; l < LEVELS; l++) begin : gLvl
    localparam int W = stageWidth(NUM_IN, l);
    localparam int F = stageAdders(NUM_IN, l);
    localparam int B = carryBase(NUM_IN, l);

    logic [W-1:0]   stIn;
    logic [W-F-1:0] stOut;

    if (l == 0) begin : gHead
      assign stIn = inBits;
    end else begin : gChain
      assign stIn = gLvl[l-1].stOut;
    end

    // Level l sends its carries to level l+1 of the upper slice, and
    // the lower slice's level-l carries join this slice after level l.
    tcs_level #(
      .IN_W(W),
      .FA_N(F)
    ) uLevel (
      .lvlIn     (stIn),
      .lateralIn (carryIn[B+:F]),
      .lvlOut    (stOut),
      .lateralOut(carryOut[B+:F])
    );
  end

  assign outBits = gLvl[LEVELS-1].stOut;

endmodule

// File: rtl/tile_counter_slice_chk.sv
module tile_counter_slice_chk
  import tcs_pkg::*;
#(
  parameter int NUM_IN = 11
) (
  input logic [NUM_IN-1:0] inBits,
  input logic [NUM_IN-3:0] carryIn,
  input logic [NUM_IN-3:0] carryOut,
  input logic [1:0]        outBits
);
  localparam int F0 = stageAdders(NUM_IN, 0);

  always_comb begin
    AST_WEIGHT_BALANCE: assert ($countones(inBits) + $countones(carryIn) ==
                                $countones(outBits) + 2 * $countones(carryOut)); // R1
    AST_QUIET_SLICE: assert (!(inBits == '0 && carryIn == '0) ||
                             (outBits == '0 && carryOut == '0)); // R2
    AST_FULL_SLICE: assert (!((&inBits) && (&carryIn)) ||
                            ((&outBits) && (&carryOut))); // R3
    AST_HEAD_CARRY_LOCAL: assert (inBits != '0 || carryOut[F0-1:0] == '0); // R4
  end
endmodule

bind tile_counter_slice tile_counter_slice_chk #(.NUM_IN(NUM_IN)) uChk (
  .inBits  (inBits),
  .carryIn (carryIn),
  .carryOut(carryOut),
  .outBits (outBits)
);

// File: tb/tb_tile_counter_slice.sv
module tb_tile_counter_slice;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // single eleven-input slice
  logic [10:0] sIn = '0;
  logic [8:0]  sCin = '0;
  logic [8:0]  sCout;
  logic [1:0]  sOut;
  tile_counter_slice #(.NUM_IN(11)) dut (
    .inBits(sIn), .carryIn(sCin), .carryOut(sCout), .outBits(sOut));

  // eighteen-input slice
  logic [17:0] xIn = '0;
  logic [15:0] xCin = '0;
  logic [15:0] xCout;
  logic [1:0]  xOut;
  tile_counter_slice #(.NUM_IN(18)) uWide (
    .inBits(xIn), .carryIn(xCin), .carryOut(xCout), .outBits(xOut));

  // chain of four slices, weight 2^k for slice k
  logic [3:0][10:0] chIn = '0;
  logic [4:0][8:0]  chLink;
  logic [3:0][1:0]  chOut;
  logic [8:0]       chBase = '0;
  assign chLink[0] = chBase;
  for (genvar k = 0; k < 4; k++) begin : gChain
    tile_counter_slice #(.NUM_IN(11)) uCh (
      .inBits(chIn[k]), .carryIn(chLink[k]), .carryOut(chLink[k+1]), .outBits(chOut[k]));
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    @(posedge clk);
  endtask

  function automatic int headCarries(input logic [17:0] v, input int groups);
    int r;
    r = 0;
    for (int i = 0; i < groups; i++)
      if ((v[3*i] + v[3*i+1] + v[3*i+2]) >= 2) r |= (1 << i);
    return r;
  endfunction

  task automatic applySingle(input logic [10:0] i, input logic [8:0] c);
    sIn = i;
    sCin = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bases[6];
    bases = '{0, 3, 5, 7, 8, 9};
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2: quiet state after reset
    chk("R2 reset outBits", sOut, 0);
    chk("R2 reset carryOut", sCout, 0);
    @(posedge clk);

    // R3: all ones
    applySingle('1, '1);
    chk("R3 outBits", sOut, 3);
    chk("R3 carryOut", sCout, 9'h1FF);
    @(posedge clk);

    // R1 and R4: every input pattern, carries low then high
    for (int c = 0; c < 2; c++) begin
      for (int v = 0; v < 2048; v++) begin
        applySingle(11'(v), c ? 9'h1FF : 9'h000);
        chk("R1 balance", $countones(sOut) + 2 * $countones(sCout),
            $countones(11'(v)) + (c ? 9 : 0));
        chk("R4 head carries", sCout[2:0], headCarries(18'(v), 3));
        @(posedge clk);
      end
    end

    // R1 and R4: every carry-in pattern with inputs low and high
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 512; c++) begin
        applySingle(f ? 11'h7FF : 11'h000, 9'(c));
        chk("R1 carry sweep", $countones(sOut) + 2 * $countones(sCout),
            (f ? 11 : 0) + $countones(9'(c)));
        chk("R4 carry-in independence", sCout[2:0], f ? 7 : 0);
        @(posedge clk);
      end
    end

    // R5: a carry-in group only disturbs higher carry-out groups
    for (int p = 0; p < 300; p++) begin
      logic [10:0] vi;
      logic [8:0]  vc;
      logic [8:0]  baseOut;
      vi = 11'($urandom);
      vc = 9'($urandom);
      applySingle(vi, vc);
      baseOut = sCout;
      @(posedge clk);
      for (int g = 0; g < 5; g++) begin
        int lowMask;
        int grpMask;
        lowMask = (1 << bases[g+1]) - 1;
        grpMask = lowMask & ~((1 << bases[g]) - 1);
        applySingle(vi, vc ^ 9'(grpMask));
        chk("R5 lower groups unchanged", sCout & 9'(lowMask), baseOut & 9'(lowMask));
        @(posedge clk);
      end
    end

    // R6: four chained slices against a weighted population count
    for (int p = 0; p < 4000; p++) begin
      longint expSum;
      longint actSum;
      for (int k = 0; k < 4; k++) chIn[k] = 11'($urandom);
      chBase = (p < 5) ? 9'h000 : ((p < 10) ? 9'h1FF : 9'($urandom));
      if (p == 1) chIn = '1;
      if (p == 2) chIn = '0;
      @(negedge clk);
      expSum = $countones(chBase);
      actSum = 16 * $countones(chLink[4]);
      for (int k = 0; k < 4; k++) begin
        expSum += (longint'(1) << k) * $countones(chIn[k]);
        actSum += (longint'(1) << k) * $countones(chOut[k]);
      end
      chk("R6 column sum", actSum, expSum);
      @(posedge clk);
    end

    // R7: eighteen-input slice
    chk("R7 lateral width", $bits(xCout), 16);
    xIn = '0; xCin = '0;
    @(negedge clk);
    chk("R7 quiet", {xOut, xCout}, 0);
    @(posedge clk);
    xIn = '1; xCin = '1;
    @(negedge clk);
    chk("R7 full", {xOut, xCout}, 18'h3FFFF);
    @(posedge clk);
    for (int p = 0; p < 4000; p++) begin
      xIn = 18'($urandom);
      xCin = 16'($urandom);
      @(negedge clk);
      chk("R7 balance", $countones(xOut) + 2 * $countones(xCout),
          $countones(xIn) + $countones(xCin));
      chk("R7 head carries", xCout[5:0], headCarries(xIn, 6));
      @(posedge clk);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule